// File: doc/BRIEF.md
# Emulated Real-Time Clock Command Handshake Unit

This block gives a host a register-bus view of an emulated real-time clock. The host writes a packed BCD date word and time word, a settings word (bit 0 picks 12-hour display mode; it is stored and returned, not interpreted) and a signed seconds offset into staging registers. None of these take effect until a command is issued through a 16-bit control register. A commit command checks the staged date and time and, if they are well formed, loads them into the live clock, latches the settings and offset, and starts the clock. A snapshot command copies the latched settings and offset into the read-back registers.

Every command holds a busy flag for a fixed number of cycles and then reports success or failure in an error flag. Software clears the control register, issues a command, waits for busy to fall, and then inspects the error flag. Once the clock is running, a one-pulse-per-second tick advances the time in BCD.

Top module: `rtc_cmd_unit`

## Requirements
- R1: After reset the control word reads 0, the date, time, settings and offset registers read 0, and the clock is stopped.
- R2: An accepted control write of 1 (commit) or 2 (snapshot) sets control bit 15 (busy) for exactly BUSY_CYCLES cycles. Control bits [1:0] hold the code of the last accepted write.
- R3: Any control write while busy is ignored. It neither restarts nor shortens the busy window, and it does not change the command code.
- R4: When a commit completes with valid staged fields, bit 14 reads 0, the live date and time take the staged values, the settings and offset are latched, and the clock runs. When the fields are invalid, bit 14 reads 1 and the live date and time do not change.
- R5: The staged fields are invalid if any nibble of year, month, day, hour, minute or second is above 9, or if month is 0 or above 0x12, or if hour is above 0x23, or if minute or second is above 0x59.
- R6: The settings and offset read-back values change only when a snapshot succeeds. A snapshot fails (bit 14 reads 1) while the clock has never been started.
- R7: An accepted control write of 0, or of any other non-command value, clears bit 14 and starts no command.
- R8: Each tick while the clock runs adds one second in BCD, with carries into minutes and hours. 23:59:59 wraps to 00:00:00, and the date word is not changed.
- R9: A tick has no effect while the clock is stopped.
- R10: Reads return data one cycle after rd_en. The addresses are 0 control, 1 date, 2 time, 3 settings and 4 offset. The date word is year[7:0], month[15:8], day[23:16], weekday[31:24]. The time word is hour[7:0], minute[15:8], second[23:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |

## Verification
The bench builds the unit with the default BUSY_CYCLES of 4. With that value it can count the busy window cycle by cycle and can land a second control write inside it. A table of staged date and time pairs covers every error rule and the month boundaries at 0x00, 0x12 and 0x13. Directed ticks then cover nibble carries, the hour boundary and the 23:59:59 wrap.

// File: rtl/rtc_cmd_pkg.sv
// Shared types, codes and field checks for the emulated clock command unit.
// Assumes the date and time words keep the byte layout given in the brief.
package rtc_cmd_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_DATE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_TIME   = 3'd2;
    localparam logic [ADDR_W-1:0] A_SETUP  = 3'd3;
    localparam logic [ADDR_W-1:0] A_OFFSET = 3'd4;

    localparam int BUSY_BIT = 15;
    localparam int ERR_BIT  = 14;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_COMMIT   = 2'd1,
        CMD_SNAPSHOT = 2'd2
    } rtc_cmd_e;

    typedef struct packed {
        logic [7:0] weekday;
        logic [7:0] day;
        logic [7:0] month;
        logic [7:0] year;
    } rtc_date_t;

    typedef struct packed {
        logic [7:0] pad;
        logic [7:0] second;
        logic [7:0] minute;
        logic [7:0] hour;
    } rtc_time_t;

    // True when both nibbles of a byte are decimal digits.
    function automatic logic bcd_byte_ok(input logic [7:0] b);
        return (b[3:0] <= 4'd9) && (b[7:4] <= 4'd9);
    endfunction

    // True when staged date and time may be loaded into the live clock.
    function automatic logic fields_ok(input rtc_date_t d, input rtc_time_t t);
        logic ok;
        ok = bcd_byte_ok(d.year) && bcd_byte_ok(d.month) && bcd_byte_ok(d.day)
          && bcd_byte_ok(t.hour) && bcd_byte_ok(t.minute) && bcd_byte_ok(t.second);
        ok = ok && (d.month != 8'h00) && (d.month <= 8'h12);
        ok = ok && (t.hour <= 8'h23) && (t.minute <= 8'h59) && (t.second <= 8'h59);
        return ok;
    endfunction

    // Adds one to a valid BCD byte.
    function automatic logic [7:0] bcd_inc(input logic [7:0] b);
        if (b[3:0] == 4'd9) return {b[7:4] + 4'd1, 4'd0};
        return {b[7:4], b[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_cmd_sequencer.sv
// Command sequencer: on an accepted start it holds busy for BUSY_CYCLES
// cycles and pulses done in the last busy cycle. It assumes the caller
// only raises start while busy is low.
module rtc_cmd_sequencer
    import rtc_cmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  rtc_cmd_e start_kind,
    output logic     busy,
    output logic     done,
    output rtc_cmd_e kind
);
    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] remain;

    // Done fires on the last busy cycle.
    assign done = busy && (remain == '0);

    // Loads the countdown on start and retires it when it reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
            kind   <= CMD_NONE;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CNT_LOAD;
            kind   <= start_kind;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/rtc_bcd_clock.sv
// Live clock: holds date and time, loads them on request and advances
// the seconds in BCD on each tick once running. Date fields are not advanced.
// Assumes the loaded values are valid BCD within range.
module rtc_bcd_clock
    import rtc_cmd_pkg::*;
#(
    parameter int NUM_FIELDS = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  rtc_date_t load_date,
    input  rtc_time_t load_time,
    input  logic      tick,
    output rtc_date_t cur_date,
    output rtc_time_t cur_time,
    output logic      running
);
    localparam logic [7:0] FIELD_MAX [NUM_FIELDS] = '{8'h59, 8'h59, 8'h23};

    logic [7:0] field     [NUM_FIELDS];
    logic [7:0] field_nxt [NUM_FIELDS];
    logic       carry     [NUM_FIELDS+1];

    assign field[0] = cur_time.second;
    assign field[1] = cur_time.minute;
    assign field[2] = cur_time.hour;
    assign carry[0] = tick && running;

    // Ripple carry from seconds up to hours.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_digit
        always_comb begin
            field_nxt[i] = field[i];
            if (carry[i])
                field_nxt[i] = (field[i] == FIELD_MAX[i]) ? 8'h00 : bcd_inc(field[i]);
        end
        assign carry[i+1] = carry[i] && (field[i] == FIELD_MAX[i]);
    end

    // Holds the live values: a load wins over a tick in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_date <= '0;
            cur_time <= '0;
            running  <= 1'b0;
        end else if (load) begin
            cur_date <= load_date;
            cur_time <= load_time;
            running  <= 1'b1;
        end else begin
            cur_time.second <= field_nxt[0];
            cur_time.minute <= field_nxt[1];
            cur_time.hour   <= field_nxt[2];
        end
    end
endmodule

// File: rtl/rtc_cmd_unit.sv
// Top of the emulated clock command unit. It keeps the staging registers,
// issues commands to the sequencer, applies them when they complete and
// serves registered reads. It assumes one bus access of each kind per cycle.
module rtc_cmd_unit
    import rtc_cmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sec_tick
);
    rtc_date_t         stage_date;
    rtc_time_t         stage_time;
    logic [DATA_W-1:0] stage_setup, stage_offset;
    logic [DATA_W-1:0] held_setup, held_offset;
    logic [DATA_W-1:0] view_setup, view_offset;
    logic              err;
    logic [1:0]        last_code;

    logic      busy, done, running;
    rtc_cmd_e  kind, new_kind;
    logic      ctrl_wr, start, stage_valid, load;
    rtc_date_t cur_date;
    rtc_time_t cur_time;
    logic [15:0] ctrl_word;

    assign ctrl_wr     = wr_en && (wr_addr == A_CTRL) && !busy;
    assign new_kind    = (wr_data[15:0] == 16'd1) ? CMD_COMMIT :
                         (wr_data[15:0] == 16'd2) ? CMD_SNAPSHOT : CMD_NONE;
    assign start       = ctrl_wr && (new_kind != CMD_NONE);
    assign stage_valid = fields_ok(stage_date, stage_time);
    assign load        = done && (kind == CMD_COMMIT) && stage_valid;
    assign ctrl_word   = {busy, err, 12'd0, last_code};

    rtc_cmd_sequencer #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_kind (new_kind),
        .busy       (busy),
        .done       (done),
        .kind       (kind)
    );

    rtc_bcd_clock u_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_date (stage_date),
        .load_time (stage_time),
        .tick      (sec_tick),
        .cur_date  (cur_date),
        .cur_time  (cur_time),
        .running   (running)
    );

    // Captures host writes into the staging registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_date   <= '0;
            stage_time   <= '0;
            stage_setup  <= '0;
            stage_offset <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_DATE:   stage_date   <= wr_data;
                A_TIME:   stage_time   <= wr_data;
                A_SETUP:  stage_setup  <= wr_data;
                A_OFFSET: stage_offset <= wr_data;
                default:  ;
            endcase
        end
    end

    // Tracks the command code and the error flag across a command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err       <= 1'b0;
            last_code <= 2'd0;
        end else if (ctrl_wr) begin
            err       <= 1'b0;
            last_code <= new_kind;
        end else if (done) begin
            err <= (kind == CMD_COMMIT) ? !stage_valid : !running;
        end
    end

    // Latches settings and offset on a good commit, exposes them on a good snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_setup  <= '0;
            held_offset <= '0;
            view_setup  <= '0;
            view_offset <= '0;
        end else if (load) begin
            held_setup  <= stage_setup;
            held_offset <= stage_offset;
        end else if (done && (kind == CMD_SNAPSHOT) && running) begin
            view_setup  <= held_setup;
            view_offset <= held_offset;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (rd_addr)
                A_CTRL:   rd_data <= {16'd0, ctrl_word};
                A_DATE:   rd_data <= cur_date;
                A_TIME:   rd_data <= cur_time;
                A_SETUP:  rd_data <= view_setup;
                A_OFFSET: rd_data <= view_offset;
                default:  rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_cmd_unit_chk.sv
// Checker for rtc_cmd_unit, attached through bind. It watches the
// sequencer, the live clock and the error flag.
module rtc_cmd_unit_chk
    import rtc_cmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input logic      clk,
    input logic      rst_n,
    input logic      wr_en,
    input logic [2:0] wr_addr,
    input logic      sec_tick,
    input logic      busy,
    input logic      done,
    input logic      err,
    input logic      running,
    input logic      load,
    input rtc_time_t cur_time
);
    logic [15:0] busy_run;

    // Counts consecutive busy cycles already seen.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= '0;
        else        busy_run <= busy ? busy_run + 16'd1 : 16'd0;
    end

    assert_busy_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < 16'(BUSY_CYCLES)));

    assert_busy_from_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && (wr_addr == A_CTRL)));

    assert_start_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> running);

    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !(wr_en && (wr_addr == A_CTRL))) |=> $stable(err));

    assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load) |=> $stable(cur_time));

    assert_seconds_bcd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cur_time.second[3:0] <= 4'd9));
endmodule

bind rtc_cmd_unit rtc_cmd_unit_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .sec_tick (sec_tick),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .running  (running),
    .load     (load),
    .cur_time (cur_time)
);

// File: tb/rtc_cmd_unit_tb.sv
// Bench for rtc_cmd_unit: a vector table of staged date and time pairs,
// then directed checks of reset, busy timing, snapshots and ticks.
module rtc_cmd_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY = 4;
    localparam int NV = 9;
    // {date, time, expect_error}
    localparam logic [64:0] VEC [NV] = '{
        {32'h03150624, 32'h00585923, 1'b0},
        {32'h01010024, 32'h00000000, 1'b1},
        {32'h01011324, 32'h00000000, 1'b1},
        {32'h06311299, 32'h00000000, 1'b0},
        {32'h01010124, 32'h00005A10, 1'b1},
        {32'h010101A0, 32'h00000000, 1'b1},
        {32'h01010124, 32'h000F0000, 1'b1},
        {32'h01010124, 32'h00000024, 1'b1},
        {32'h02281202, 32'h00590909, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, sec_tick = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_cmd_unit #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .sec_tick(sec_tick)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        d = rd_data; rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int i = 0; i < 50; i++) begin
            bus_read(3'd0, c);
            if (!c[15]) break;
        end
    endtask

    task automatic run_cmd(input logic [31:0] code, output logic [31:0] ctrl);
        bus_write(3'd0, 32'd0);
        bus_write(3'd0, code);
        wait_idle();
        bus_read(3'd0, ctrl);
    endtask

    task automatic pulse_tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r, ctrl, good_date, good_time;
        int nbusy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R10 addresses
        bus_read(3'd0, r); check("R1 ctrl", r, 32'd0);
        bus_read(3'd1, r); check("R1 date", r, 32'd0);
        bus_read(3'd2, r); check("R1 time", r, 32'd0);
        bus_read(3'd3, r); check("R1 setup", r, 32'd0);
        bus_read(3'd4, r); check("R1 offset", r, 32'd0);

        // R9 tick while stopped
        pulse_tick();
        bus_read(3'd2, r); check("R9 stopped tick", r, 32'd0);

        // R6 snapshot fails before the clock starts
        run_cmd(32'd2, ctrl); check("R6 snapshot err", {31'd0, ctrl[14]}, 32'd1);

        // R7 write 0 clears error
        bus_write(3'd0, 32'd0);
        bus_read(3'd0, r); check("R7 clear err", r, 32'd0);

        bus_write(3'd3, 32'h000000A5);
        bus_write(3'd4, 32'hFFFFFFF0);

        // R4 R5 vector walk
        good_date = '0; good_time = '0;
        for (int v = 0; v < NV; v++) begin
            bus_write(3'd1, VEC[v][64:33]);
            bus_write(3'd2, VEC[v][32:1]);
            run_cmd(32'd1, ctrl);
            check("R5 error flag", {31'd0, ctrl[14]}, {31'd0, VEC[v][0]});
            if (!VEC[v][0]) begin
                good_date = VEC[v][64:33];
                good_time = VEC[v][32:1];
            end
            bus_read(3'd1, r); check("R4 date", r, good_date);
            bus_read(3'd2, r); check("R4 time", r, good_time);
        end

        // R6 readback unchanged until snapshot
        bus_read(3'd3, r); check("R6 setup before snapshot", r, 32'd0);
        run_cmd(32'd2, ctrl); check("R6 snapshot ok", {31'd0, ctrl[14]}, 32'd0);
        bus_read(3'd3, r); check("R6 setup", r, 32'h000000A5);
        bus_read(3'd4, r); check("R6 offset", r, 32'hFFFFFFF0);
        bus_write(3'd3, 32'h0000005A);
        run_cmd(32'd2, ctrl);
        bus_read(3'd3, r); check("R6 uncommitted setup", r, 32'h000000A5);

        // R8 nibble carry 09:09:59 -> 09:10:00
        pulse_tick();
        bus_read(3'd2, r); check("R8 minute carry", r, 32'h00001009);

        // R2 busy lasts exactly BUSY cycles, code readable
        bus_write(3'd0, 32'd1);
        nbusy = 0;
        rd_en = 1'b1; rd_addr = 3'd0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (rd_data[15]) nbusy++;
        end
        rd_en = 1'b0;
        check("R2 busy cycles", nbusy, BUSY);
        bus_read(3'd0, r); check("R2 code", r, 32'h00000001);
        bus_read(3'd3, r); check("R6 commit alone", r, 32'h000000A5);

        // R3 write while busy ignored
        bus_write(3'd0, 32'd1);
        bus_write(3'd0, 32'd0);
        nbusy = 0;
        rd_en = 1'b1; rd_addr = 3'd0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (rd_data[15]) nbusy++;
        end
        rd_en = 1'b0;
        check("R3 busy not cut", nbusy, BUSY - 1);
        bus_read(3'd0, r); check("R3 code kept", r, 32'h00000001);

        // R7 non-command value clears error without busy
        bus_write(3'd2, 32'h00000099);
        run_cmd(32'd1, ctrl); check("R5 bad hour", {31'd0, ctrl[14]}, 32'd1);
        bus_write(3'd0, 32'd7);
        bus_read(3'd0, r); check("R7 other value", r, 32'd0);

        // R8 hour carry and day wrap, date unchanged
        bus_write(3'd1, 32'h02281202);
        bus_write(3'd2, 32'h00595912);
        run_cmd(32'd1, ctrl);
        pulse_tick();
        bus_read(3'd2, r); check("R8 hour carry", r, 32'h00000013);
        bus_write(3'd2, 32'h00585923);
        run_cmd(32'd1, ctrl);
        pulse_tick();
        bus_read(3'd2, r); check("R8 plain second", r, 32'h00595923);
        pulse_tick();
        bus_read(3'd2, r); check("R8 wrap", r, 32'h00000000);
        bus_read(3'd1, r); check("R8 date kept", r, 32'h02281202);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule